// File: doc/BRIEF.md
# RTC Periodic Tick Timer

This block produces a periodic interrupt derived from a 32768 Hz base strobe. The base strobe passes through a power-of-two divider whose ratio comes from a 4-bit select field. The divided strobe decrements a down-counter. When the count runs out, the block sets a pending flag, raises a level interrupt, and reloads the counter from a programmed period value. The counter keeps running after each reload.

Software reaches the block through a small register port. Writes take one cycle and reads are combinational. There are four registers: a control word, the period value, a read-only view of the live count, and a pending flag cleared by writing one. The timer starts and stops only on changes of the enable bits, not on their levels. Period values that are too small are discarded.

Top module: `rtc_tick_timer`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low, and base strobes leave the live count at 0.
- R2: A write to address 1 (period) is kept only when the value is greater than 2 and below 2^CNT_W. Any other write leaves the previous period in place.
- R3: With select value s (control bits 7:4), a running counter decrements once every 2^s base strobes, counted from the start of the run.
- R4: A control write (address 0) with bit 0 set that changes bit 8 from 0 to 1 does two things when the period is nonzero: it loads the live count from the period and starts the counter. When the period is zero the counter stays stopped.
- R5: A control write with bit 0 set that changes bit 8 from 1 to 0 stops the counter, and the live count holds its value.
- R6: A control write that changes bit 0 from 1 to 0 stops the counter.
- R7: Changes of bit 8 in a control write whose bit 0 is 0 neither start nor stop the counter.
- R8: A divided strobe that arrives while the live count is 1 does three things: it sets bit 0 of address 3, drives `irq_o` high, and reloads the live count from the period. The counter keeps running, so the interrupt period is N divided strobes for a period value N.
- R9: A write to address 3 with bit 0 set clears the pending bit and `irq_o`. A write with bit 0 clear changes nothing. If an expiry falls in the same cycle as the clear, the pending bit stays set.
- R10: A change of the select field while running takes effect at the next divided boundary. It neither reloads nor resets the live count.
- R11: Reads decode as follows:
  - Address 0 returns bit 0, bits 7:4 and bit 8 as written, with every other bit 0.
  - Address 1 returns the period.
  - Address 2 returns the live count. Writes to address 2 are ignored.
  - Address 3 returns the pending bit in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_tick_i | input | 1 | One-cycle strobe at the 32768 Hz base rate |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 32 | Read data, combinational |
| irq_o | output | 1 | Tick interrupt, level, follows the pending bit |

## Verification
The bench goes after the edge-only start rule in four situations: a zero period at start, a tick-enable edge while the RTC enable bit is clear, a rewrite that leaves tick enable high, and a fall of the RTC enable bit. A level-sensitive design would restart or reload the counter in these cases, or fail to stop it. Period writes of 0, 2 and an oversized value check that small or truncated periods cannot slip in and produce an interrupt storm. A select change in mid-run checks that the divider is not restarted, which would stretch one tick interval. The bench also sweeps expiry and write-one-to-clear under random traffic. A design that reloads off by one shows a wrong interrupt period, and a design that ignores a clear, or clears on a written zero, leaves `irq_o` wrong.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PRD  = 2'd1,
    ADDR_CUR  = 2'd2,
    ADDR_PEND = 2'd3
  } reg_addr_e;

  // control field positions are software visible
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_SEL_LSB = 4;
  localparam int CTRL_TEN_BIT = 8;

  // period writes must exceed this
  localparam int PRD_MIN = 2;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             base_tick_i,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             strobe_o
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = SEL_W'(i) < sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pre_q <= '0;
    else if (clear_i)            pre_q <= '0;
    else if (run_i && base_tick_i) pre_q <= pre_q + 1'b1;
  end

  // boundary when all selected low bits are ones
  assign strobe_o = run_i && base_tick_i && !clear_i && ((pre_q & mask) == mask);
endmodule

// File: rtl/tick_downcounter.sv
module tick_downcounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             strobe_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cur_o,
  output logic             expire_o
);
  logic             run_q;
  logic [CNT_W-1:0] cur_q;

  assign expire_o = run_q && strobe_i && !stop_i && (cur_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cur_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      cur_q <= reload_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q && strobe_i) begin
      cur_q <= expire_o ? reload_i : cur_q - 1'b1;
    end
  end

  assign run_o = run_q;
  assign cur_o = cur_q;
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  input  logic [CNT_W-1:0]  cur_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CNT_W-1:0]  prd_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              pend_o
);
  logic             en_q, ten_q, pend_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] prd_q;

  logic wr_ctrl, wr_prd, wr_pend;
  logic en_new, ten_new, prd_ok;

  always_comb begin
    wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
    wr_prd  = wr_en_i && (wr_addr_i == ADDR_PRD);
    wr_pend = wr_en_i && (wr_addr_i == ADDR_PEND);
    en_new  = wr_data_i[CTRL_EN_BIT];
    ten_new = wr_data_i[CTRL_TEN_BIT];
    prd_ok  = (wr_data_i > DATA_W'(PRD_MIN)) && ((wr_data_i >> CNT_W) == '0);
  end

  assign start_o = wr_ctrl && en_new && ten_new && !ten_q && (prd_q != '0);
  assign stop_o  = wr_ctrl && ((en_new && !ten_new && ten_q) || (!en_new && en_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ten_q <= 1'b0;
      sel_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= en_new;
      ten_q <= ten_new;
      sel_q <= wr_data_i[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              prd_q <= '0;
    else if (wr_prd && prd_ok) prd_q <= wr_data_i[CNT_W-1:0];
  end

  // expiry wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pend_q <= 1'b0;
    else if (expire_i)                 pend_q <= 1'b1;
    else if (wr_pend && wr_data_i[0])  pend_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    unique case (reg_addr_e'(rd_addr_i))
      ADDR_CTRL: begin
        rd_data_o[CTRL_EN_BIT]              = en_q;
        rd_data_o[CTRL_TEN_BIT]             = ten_q;
        rd_data_o[CTRL_SEL_LSB +: SEL_W]    = sel_q;
      end
      ADDR_PRD:  rd_data_o[CNT_W-1:0] = prd_q;
      ADDR_CUR:  rd_data_o[CNT_W-1:0] = cur_i;
      ADDR_PEND: rd_data_o[0]         = pend_q;
      default:   rd_data_o = '0;
    endcase
  end

  assign sel_o  = sel_q;
  assign prd_o  = prd_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/rtc_tick_timer.sv
module rtc_tick_timer
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              base_tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] prd, cur;
  logic             start, stop, run, strobe, expire, pend;

  tick_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .cur_i     (cur),
    .expire_i  (expire),
    .rd_data_o (rd_data_o),
    .sel_o     (sel),
    .prd_o     (prd),
    .start_o   (start),
    .stop_o    (stop),
    .pend_o    (pend)
  );

  tick_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .base_tick_i (base_tick_i),
    .run_i       (run),
    .clear_i     (start),
    .sel_i       (sel),
    .strobe_o    (strobe)
  );

  tick_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .stop_i   (stop),
    .strobe_i (strobe),
    .reload_i (prd),
    .run_o    (run),
    .cur_o    (cur),
    .expire_o (expire)
  );

  assign irq_o = pend;
endmodule

// File: rtl/rtc_tick_timer_chk.sv
module rtc_tick_timer_chk
  import rtc_tick_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              irq_o,
  input logic [CNT_W-1:0]  prd,
  input logic [CNT_W-1:0]  cur,
  input logic              run,
  input logic              start,
  input logic              stop,
  input logic              strobe,
  input logic              expire
);
  AST_PRD_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_PRD && wr_data_i <= DATA_W'(PRD_MIN)) |=> $stable(prd)); // R2

  AST_EXPIRE_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> irq_o); // R8

  AST_EXPIRE_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !start) |=> (run && cur == $past(prd))); // R8

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (run && cur == $past(prd))); // R4

  AST_STOP_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> !run); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !start) |=> $stable(cur)); // R1

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && strobe && !expire && !start && !stop) |=> (cur == $past(cur) - 1'b1)); // R3

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_PEND && wr_data_i[0] && !expire) |=> !irq_o); // R9
endmodule

bind rtc_tick_timer rtc_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .prd       (prd),
  .cur       (cur),
  .run       (run),
  .start     (start),
  .stop      (stop),
  .strobe    (strobe),
  .expire    (expire)
);

// File: tb/rtc_tick_timer_test.sv
module rtc_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  int unsigned m_ctrl = 0, m_prd = 0, m_cur = 0;
  bit          m_run = 0, m_pend = 0;
  logic [14:0] m_pre = '0;

  always #5 clk = ~clk;

  rtc_tick_timer uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .base_tick_i (base_tick),
    .wr_en_i     (wr_en),
    .wr_addr_i   (wr_addr),
    .wr_data_i   (wr_data),
    .rd_addr_i   (rd_addr),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  function automatic int unsigned exp_reg(int a);
    case (a)
      0:       return m_ctrl & 32'h1F1;
      1:       return m_prd;
      2:       return m_cur;
      default: return {31'd0, m_pend};
    endcase
  endfunction

  function automatic void model_write(int a, int unsigned d);
    bit en_new = d[0], ten_new = d[8];
    bit en_old = m_ctrl[0], ten_old = m_ctrl[8];
    case (a)
      0: begin
        if (en_new && ten_new && !ten_old && m_prd != 0) begin
          m_cur = m_prd; m_run = 1; m_pre = '0;
        end
        if (en_new && !ten_new && ten_old) m_run = 0;
        if (!en_new && en_old) m_run = 0;
        m_ctrl = d & 32'h1F1;
      end
      1: if (d > 2 && d < 32'h10000) m_prd = d;
      3: if (d[0]) m_pend = 0;
      default: ;
    endcase
  endfunction

  function automatic void model_tick();
    logic [14:0] mask;
    if (m_run) begin
      mask = (15'(1) << m_ctrl[7:4]) - 15'(1);
      if ((m_pre & mask) == mask) begin
        if (m_cur <= 1) begin m_cur = m_prd; m_pend = 1; end
        else m_cur = m_cur - 1;
      end
      m_pre = m_pre + 15'(1);
    end
  endfunction

  task automatic chk(string tag, string what, int unsigned got, int unsigned exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #0.8;
      chk(tag, $sformatf("reg%0d", a), rd_data, exp_reg(a));
    end
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_pend});
  endtask

  task automatic do_write(int a, int unsigned d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      base_tick = 1'b1;
      @(negedge clk);
      base_tick = 1'b0;
      model_tick();
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(3_000_000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    do_tick(3);
    check_all("R1");

    // zero period: no start
    do_write(0, 32'h101);
    do_tick(2);
    check_all("R4");
    do_write(0, 32'h001);

    do_write(1, 5);     check_all("R2");
    do_write(1, 2);     check_all("R2");
    do_write(1, 0);     check_all("R2");
    do_write(1, 32'h10005); check_all("R2");
    do_write(1, 3);     check_all("R2");
    do_write(1, 5);

    // tick enable edges ignored with RTC enable clear
    do_write(0, 32'h000);
    do_write(0, 32'h100);
    do_tick(2);
    check_all("R7");
    do_write(0, 32'h000);
    check_all("R7");

    // divide by 4
    do_write(0, 32'h121);
    check_all("R4");
    do_tick(3); check_all("R3");
    do_tick(1); check_all("R3");
    for (int k = 0; k < 4; k++) begin
      do_tick(4);
      check_all("R8");
    end

    do_write(3, 0); check_all("R9");
    do_write(3, 1); check_all("R9");

    // select change mid-run, count kept
    do_tick(2);
    do_write(0, 32'h101);
    check_all("R10");
    do_tick(1); check_all("R10");
    do_tick(1); check_all("R10");

    do_write(0, 32'h001);
    do_tick(3); check_all("R5");

    do_write(0, 32'h101); check_all("R4");
    do_tick(1);
    do_write(0, 32'h100);
    do_tick(3); check_all("R6");

    do_write(2, 32'hFFFF); check_all("R11");
    do_write(0, 32'hFFFF_FFFF); check_all("R11");
    do_write(0, 32'h0);

    // random traffic
    for (int it = 0; it < 500; it++) begin
      int unsigned r = $urandom % 10;
      if (r < 6) begin
        do_tick(1);
      end else if (r < 8) begin
        int unsigned d = (($urandom % 4) != 0 ? 32'h1 : 32'h0) |
                         (($urandom % 2) != 0 ? 32'h100 : 32'h0) |
                         (($urandom % 3) << 4);
        do_write(0, d);
      end else if (r < 9) begin
        do_write(1, $urandom % 10);
      end else begin
        do_write(3, $urandom % 2);
      end
      check_all("R3 R8 R9 rnd");
    end

    done = 1'b1;
    finish_run();
  end
endmodule